// File: doc/BRIEF.md
# Inter-Processor and Timer Interrupt Controller

This block holds two pending vectors with one bit per processor, for up to four processors. The first vector holds inter-processor interrupts and the second holds interval-timer interrupts. Each pending bit drives its own interrupt line to its processor. Software changes the vectors through a 64-bit register bus. A shared control register has separate nibbles that request inter-processor interrupts, clear them and clear timer interrupts, all in one write. Dedicated registers read a vector, clear bits in it, or post inter-processor interrupts.

An external periodic tick posts the timer interrupt to every present processor. Reading the control register returns the identifier of the processor making the access, together with both vectors. The block raises a one-cycle error pulse for illegal writes. It raises a one-cycle redundancy pulse when software asks for a change that is already in effect.

Top module: `ipi_tmr_intc`

## Requirements
- R1: After reset both pending vectors are zero, all interrupt lines are low, and `err_o`, `redund_o` and `rdata_o` are zero.
- R2: A write to the control register (address 0) sets inter-processor pending for each processor whose bit is set in data bits 15:12 (bit 12 is processor 0). The line rises on the clock edge that takes the write.
- R3: In a control-register write, data bits 11:8 clear inter-processor pending and data bits 7:4 clear timer pending, for each processor whose bit is set (the lowest bit of each nibble is processor 0).
- R4: If one write both clears and requests the same processor, the clear is applied first. The processor ends up pending, and the request is not counted as redundant.
- R5: When `tick_i` is high on a clock edge, timer pending is set for every present processor. This holds even if the same edge clears timer bits.
- R6: A read of address 0 returns `cpu_id_i` in bits 1:0, the inter-processor vector in bits 11:8 and the timer vector in bits 7:4. All other bits are zero. Read data appears on `rdata_o` after the clock edge that takes the read and is held until the next read.
- R7: Address 1 reads the inter-processor vector in bits 3:0, and a write to it clears the bits set in data bits 3:0. Address 2 does the same for the timer vector. A write to address 3 posts inter-processor interrupts for the bits set in data bits 3:0, and a read of address 3 returns zero.
- R8: `err_o` pulses for one cycle after either of two illegal writes. The first is a control-register write in which bits 15:12, 11:8 and 7:4 are all zero and bit 28 is also zero. The second is a write to address 1, 2 or 3 with data bits 3:0 all zero. A control-register write with only bit 28 set is accepted and changes no state.
- R9: `redund_o` pulses for one cycle after a write that requests an inter-processor interrupt for a processor already pending. It also pulses after a write that clears one for a present processor that is not pending. Neither case changes the vector.
- R10: With `NCPU` processors present, mask bits for processor numbers `NCPU` and above are ignored. Their pending bits and interrupt lines stay zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel_i | input | 1 | Register access this cycle |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 2 | Register index: 0 control, 1 IPI vector, 2 timer vector, 3 IPI post |
| bus_wdata_i | input | 64 | Write data |
| cpu_id_i | input | 2 | Identifier of the accessing processor |
| tick_i | input | 1 | Periodic timer tick |
| rdata_o | output | 64 | Registered read data |
| ipi_irq_o | output | 4 | Inter-processor interrupt line per processor |
| tmr_irq_o | output | 4 | Timer interrupt line per processor |
| err_o | output | 1 | One-cycle pulse after an illegal write |
| redund_o | output | 1 | One-cycle pulse after a redundant request or clear |

## Verification
Every result comes one register stage after its cause. A write or tick taken at a rising edge shows on the interrupt lines, `err_o` and `redund_o` straight after that edge. A read shows on `rdata_o` straight after its edge. The bench drives inputs on the falling edge and releases them on the next falling edge. It samples outputs at that same falling edge, half a cycle after the edge that acted. The error and redundancy pulses are therefore seen in their only high cycle, and the bench checks that they have dropped by the next access.

// File: rtl/ipi_tmr_intc.sv
module ipi_tmr_intc #(
  parameter int NCPU = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_sel_i,
  input  logic        bus_wr_i,
  input  logic [1:0]  bus_addr_i,
  input  logic [63:0] bus_wdata_i,
  input  logic [1:0]  cpu_id_i,
  input  logic        tick_i,
  output logic [63:0] rdata_o,
  output logic [3:0]  ipi_irq_o,
  output logic [3:0]  tmr_irq_o,
  output logic        err_o,
  output logic        redund_o
);

  localparam logic [3:0] PRES = 4'((1 << NCPU) - 1);
  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_IPI  = 2'd1;
  localparam logic [1:0] A_TMR  = 2'd2;
  localparam logic [1:0] A_POST = 2'd3;

  logic [3:0] ipi_q, tmr_q;
  logic [3:0] req_raw, clr_raw, tclr_raw;
  logic [3:0] req_m, clr_m, tclr_m, ipi_mid;
  logic       bad_wr;
  logic [63:0] rd_val;

  wire wr = bus_sel_i & bus_wr_i;
  wire rd = bus_sel_i & ~bus_wr_i;
  wire [3:0] lo_nib = bus_wdata_i[3:0];

  logic unused_bits;
  assign unused_bits = ^{bus_wdata_i[63:29], bus_wdata_i[27:16]};

  always_comb begin
    req_raw  = '0;
    clr_raw  = '0;
    tclr_raw = '0;
    bad_wr   = 1'b0;
    if (wr) begin
      case (bus_addr_i)
        A_CTRL: begin
          req_raw  = bus_wdata_i[15:12];
          clr_raw  = bus_wdata_i[11:8];
          tclr_raw = bus_wdata_i[7:4];
          bad_wr   = ~|{bus_wdata_i[15:4], bus_wdata_i[28]};
        end
        A_IPI:  begin clr_raw  = lo_nib; bad_wr = ~|lo_nib; end
        A_TMR:  begin tclr_raw = lo_nib; bad_wr = ~|lo_nib; end
        default: begin req_raw = lo_nib; bad_wr = ~|lo_nib; end
      endcase
    end
  end

  assign req_m   = req_raw & PRES;
  assign clr_m   = clr_raw & PRES;
  assign tclr_m  = tclr_raw & PRES;
  assign ipi_mid = ipi_q & ~clr_m;

  always_comb begin
    case (bus_addr_i)
      A_CTRL:  rd_val = {52'd0, ipi_q, tmr_q, 2'b00, cpu_id_i};
      A_IPI:   rd_val = {60'd0, ipi_q};
      A_TMR:   rd_val = {60'd0, tmr_q};
      default: rd_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ipi_q    <= '0;
      tmr_q    <= '0;
      rdata_o  <= '0;
      err_o    <= 1'b0;
      redund_o <= 1'b0;
    end else begin
      ipi_q    <= ipi_mid | req_m;
      tmr_q    <= (tmr_q & ~tclr_m) | (tick_i ? PRES : 4'd0);
      err_o    <= bad_wr;
      redund_o <= |(clr_m & ~ipi_q) | |(req_m & ipi_mid);
      if (rd) rdata_o <= rd_val;
    end
  end

  assign ipi_irq_o = ipi_q;
  assign tmr_irq_o = tmr_q;

  AST_ABSENT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ((ipi_irq_o | tmr_irq_o) & ~PRES) == 4'd0); // R10

  AST_TICK_POSTS: assert property (@(posedge clk) disable iff (!rst_n)
    tick_i |=> (tmr_irq_o & PRES) == PRES); // R5

  AST_REQ_POSTS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && bus_addr_i == A_CTRL)
      |=> (ipi_irq_o & $past(bus_wdata_i[15:12]) & PRES) == ($past(bus_wdata_i[15:12]) & PRES)); // R2

  AST_TMR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && bus_addr_i == A_CTRL && !tick_i)
      |=> (tmr_irq_o & $past(bus_wdata_i[7:4])) == 4'd0); // R3

  AST_ACK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && bus_addr_i == A_CTRL && !tick_i && bus_wdata_i[28] && bus_wdata_i[15:4] == 12'd0)
      |=> ($stable(ipi_irq_o) && $stable(tmr_irq_o) && !err_o)); // R8

endmodule

// File: tb/ipi_tmr_intc_tb.sv
module ipi_tmr_intc_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel = 1'b0, wr = 1'b0, tick = 1'b0;
  logic [1:0]  addr = '0, cid = '0;
  logic [63:0] wdata = '0;
  logic [63:0] rdata;
  logic [3:0]  ipi, tmr;
  logic        err, red;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  ipi_tmr_intc #(.NCPU(3)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_sel_i(sel), .bus_wr_i(wr),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .cpu_id_i(cid), .tick_i(tick),
    .rdata_o(rdata), .ipi_irq_o(ipi), .tmr_irq_o(tmr),
    .err_o(err), .redund_o(red));

  task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  task automatic access(input logic w, input logic [1:0] a, input logic [63:0] d, input logic tk);
    @(negedge clk);
    sel = 1'b1; wr = w; addr = a; wdata = d; tick = tk;
    @(negedge clk);
    sel = 1'b0; wr = 1'b0; tick = 1'b0; wdata = '0;
  endtask

  task automatic pulse_tick();
    @(negedge clk);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 ipi", ipi, 0); check("R1 tmr", tmr, 0);
    check("R1 err", err, 0); check("R1 red", red, 0);
    check("R1 rdata", rdata, 0);
  endtask

  task automatic t_post();
    access(1, 2'd0, 64'h3000, 0);
    check("R2 ipi", ipi, 4'b0011); check("R2 err", err, 0);
    check("R2 red", red, 0);
    access(1, 2'd3, 64'h1, 0);
    check("R9 redundant req flag", red, 1); check("R9 ipi kept", ipi, 4'b0011);
  endtask

  task automatic t_clear();
    access(1, 2'd0, 64'h100, 0);
    check("R3 ipi clr", ipi, 4'b0010); check("R3 red", red, 0);
    access(1, 2'd0, 64'h100, 0);
    check("R9 redundant clr flag", red, 1); check("R9 ipi", ipi, 4'b0010);
  endtask

  task automatic t_tick();
    pulse_tick();
    check("R5 tick", tmr, 4'b0111);
    cid = 2'd2;
    access(0, 2'd0, 64'h0, 0);
    check("R6 ctrl read", rdata, 64'h272);
    access(1, 2'd0, 64'h50, 0);
    check("R3 tmr clr", tmr, 4'b0010); check("R3 ipi kept", ipi, 4'b0010);
  endtask

  task automatic t_order();
    access(1, 2'd0, 64'h2200, 0);
    check("R4 clr then req", ipi, 4'b0010); check("R4 red", red, 0);
    access(1, 2'd0, 64'h20, 1);
    check("R5 tick beats clr", tmr, 4'b0111);
  endtask

  task automatic t_dedicated();
    access(0, 2'd1, 64'h0, 0);
    check("R7 read ipi", rdata, 64'h2);
    access(1, 2'd2, 64'h7, 0);
    check("R7 tmr clr", tmr, 0);
    access(1, 2'd3, 64'h9, 0);
    check("R7 post", ipi, 4'b0011); check("R10 absent post", ipi[3], 0);
    access(0, 2'd2, 64'h0, 0);
    check("R7 read tmr", rdata, 64'h0);
    access(0, 2'd3, 64'h0, 0);
    check("R7 read post reg", rdata, 64'h0);
  endtask

  task automatic t_err();
    access(1, 2'd0, 64'h0, 0);
    check("R8 empty ctrl", err, 1);
    @(negedge clk);
    check("R8 pulse drops", err, 0);
    access(1, 2'd1, 64'hF0, 0);
    check("R8 zero mask", err, 1); check("R8 ipi kept", ipi, 4'b0011);
    access(1, 2'd0, 64'h1000_0000, 0);
    check("R8 ack err", err, 0); check("R8 ack ipi", ipi, 4'b0011);
    check("R8 ack tmr", tmr, 0);
    access(1, 2'd0, 64'h8000, 0);
    check("R10 absent req", ipi, 4'b0011); check("R10 err", err, 0);
    access(0, 2'd0, 64'h0, 0);
    check("R10 ctrl read", rdata, 64'h302);
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_post();
    t_clear();
    t_tick();
    t_order();
    t_dedicated();
    t_err();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule